// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the fetch stage for a compact byte-encoded instruction set. It owns the program counter. Each cycle the instruction memory outside the block returns a six-byte window starting at that counter. The block splits the window into an instruction code, a function code, two register specifiers and a 32-bit constant. It works out how long the instruction is (1, 2, 5 or 6 bytes) and the address that follows it, and it flags encodings that are not legal. Execution happens downstream.

The window arrives on a valid/ready input, and the decoded instruction leaves on a valid/ready output. The decoder has no storage between the two, so one handshake passes straight through to the other. The output is valid when a window is offered and the block is still running. The window is accepted exactly when the consumer takes the decoded instruction. Back-pressure from the consumer stalls the fetch, and the program counter holds until a transfer completes.

A redirect pin loads an external next address. The block stops when a halt or an illegal instruction is transferred. The stop holds until reset, and a status output reports why the block stopped.

Top module: `fetch_decode`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pc` is 0 and `stat` is 0, which means running.
- R2: `icode` is bits 7:4 of window byte 0 and `ifun` is bits 3:0 of that byte. Byte 0 is `win_data[7:0]`, and byte k is `win_data[8k+7:8k]`.
- R3: `ilen` is set by `icode`. Codes 0 (halt), 1 (nop) and 9 (return) give 1. Codes 2 (register move), 6 (arithmetic), A (push) and B (pop) give 2. Codes 3 (immediate move), 4 (register to memory) and 5 (memory to register) give 6. Codes 7 (jump) and 8 (call) give 5. Illegal codes give 1.
- R4: When `ilen` is 2 or 6, `ra` is bits 7:4 of byte 1 and `rb` is bits 3:0 of byte 1. For every other length, both are 8, which means no register.
- R5: `valc` holds a little-endian constant. For 6-byte instructions it is taken from bytes 2..5. For 5-byte instructions it is taken from bytes 1..4. For every other instruction it is 0.
- R6: `valp` equals `pc + ilen`, modulo 2^32.
- R7: `bad` is 1 in three cases: `icode` is above B; `icode` is 6 and `ifun` is above 3; or `icode` is 7 and `ifun` is above 6.
- R8: A transfer is `dec_vld && dec_rdy`. When a transfer completes with no redirect and no stop, `pc` takes `valp` on the next cycle. Without a transfer or a redirect, `pc` holds.
- R9: While running, `redir` loads `redir_pc` into `pc` on the next cycle. It takes priority over the advance and does not need a transfer.
- R10: When a halt is transferred, `stat` becomes 1. When an instruction with `bad` set is transferred, `stat` becomes 2. From then until reset, `stat` and `pc` hold, `pc` keeps the address of the stopping instruction, and `redir` has no effect.
- R11: `dec_vld` equals `win_vld` while running and is 0 once stopped. `win_rdy` equals `dec_rdy` while running and is 0 once stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_vld | input | 1 | Fetch window valid |
| win_rdy | output | 1 | Fetch window accepted when high with win_vld |
| win_data | input | 48 | Six bytes read at pc, byte 0 in the low bits |
| redir | input | 1 | Load redir_pc into pc |
| redir_pc | input | 32 | Redirect target address |
| dec_vld | output | 1 | Decoded instruction valid |
| dec_rdy | input | 1 | Consumer ready for the decoded instruction |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier, 8 when absent |
| rb | output | 4 | Second register specifier, 8 when absent |
| valc | output | 32 | Constant or destination |
| ilen | output | 3 | Instruction length in bytes |
| valp | output | 32 | Fall-through address |
| bad | output | 1 | Illegal encoding |
| pc | output | 32 | Program counter |
| stat | output | 2 | 0 running, 1 halted, 2 stopped on an illegal instruction |

## Verification
The bench runs a program that contains every instruction class. It applies irregular valid and ready patterns and occasional redirects, and compares every output each cycle against a behavioural model. Each corner case is aimed at a specific fault. A 5-byte jump or call is probed because a decoder that misplaced its constant would read it one byte late. A redirect to address 0xFFFFFFFE under a 6-byte instruction tests wrap-around; a wrong adder width would give a fall-through address other than 4. After a halt, and after each illegal form (code C, arithmetic function 4, jump function 7), the bench keeps offering windows and redirects. A faulty stop would let the counter move or leave the handshake live. A near-limit jump function of 6 checks that the illegal-function check is not one step too wide.

// File: rtl/fd_pkg.sv
`timescale 1ns/1ps
package fd_pkg;
  localparam logic [3:0] IC_HALT  = 4'h0;
  localparam logic [3:0] IC_NOP   = 4'h1;
  localparam logic [3:0] IC_RRMOV = 4'h2;
  localparam logic [3:0] IC_IRMOV = 4'h3;
  localparam logic [3:0] IC_RMMOV = 4'h4;
  localparam logic [3:0] IC_MRMOV = 4'h5;
  localparam logic [3:0] IC_ALU   = 4'h6;
  localparam logic [3:0] IC_JMP   = 4'h7;
  localparam logic [3:0] IC_CALL  = 4'h8;
  localparam logic [3:0] IC_RET   = 4'h9;
  localparam logic [3:0] IC_PUSH  = 4'hA;
  localparam logic [3:0] IC_POP   = 4'hB;

  localparam logic [3:0] ALU_FN_MAX = 4'd3;
  localparam logic [3:0] JMP_FN_MAX = 4'd6;
  localparam logic [3:0] REG_NONE   = 4'h8;

  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_HALT = 2'd1;
  localparam logic [1:0] ST_BAD  = 2'd2;

  typedef struct packed {
    logic       has_regs;
    logic       has_const;
    logic       const_at1;
    logic [2:0] len;
    logic       bad;
  } fmt_t;
endpackage

// File: rtl/fd_len_dec.sv
`timescale 1ns/1ps
module fd_len_dec
  import fd_pkg::*;
(
  input  logic [7:0] op_byte,
  output fmt_t       fmt
);
  logic [3:0] ic;
  logic [3:0] fn;
  assign ic = op_byte[7:4];
  assign fn = op_byte[3:0];

  always_comb begin
    fmt     = '0;
    fmt.len = 3'd1;
    case (ic)
      IC_HALT, IC_NOP, IC_RET: fmt.len = 3'd1;
      IC_RRMOV, IC_PUSH, IC_POP: begin
        fmt.len      = 3'd2;
        fmt.has_regs = 1'b1;
      end
      IC_ALU: begin
        fmt.len      = 3'd2;
        fmt.has_regs = 1'b1;
        fmt.bad      = (fn > ALU_FN_MAX);
      end
      IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
        fmt.len       = 3'd6;
        fmt.has_regs  = 1'b1;
        fmt.has_const = 1'b1;
      end
      IC_JMP: begin
        fmt.len       = 3'd5;
        fmt.has_const = 1'b1;
        fmt.const_at1 = 1'b1;
        fmt.bad       = (fn > JMP_FN_MAX);
      end
      IC_CALL: begin
        fmt.len       = 3'd5;
        fmt.has_const = 1'b1;
        fmt.const_at1 = 1'b1;
      end
      default: fmt.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/fd_field_ext.sv
`timescale 1ns/1ps
module fd_field_ext
  import fd_pkg::*;
#(
  parameter int CW = 32,
  localparam int CB = CW / 8,
  localparam int WB = CB + 2
)(
  input  logic [8*WB-1:0] win,
  input  fmt_t            fmt,
  output logic [3:0]      ra,
  output logic [3:0]      rb,
  output logic [CW-1:0]   valc
);
  logic [CW-1:0] c_after_regs;
  logic [CW-1:0] c_after_op;

  for (genvar k = 0; k < CB; k++) begin : g_cbyte
    assign c_after_regs[8*k +: 8] = win[8*(k+2) +: 8];
    assign c_after_op[8*k +: 8]   = win[8*(k+1) +: 8];
  end

  always_comb begin
    ra   = REG_NONE;
    rb   = REG_NONE;
    valc = '0;
    if (fmt.has_regs) begin
      ra = win[15:12];
      rb = win[11:8];
    end
    if (fmt.has_const)
      valc = fmt.const_at1 ? c_after_op : c_after_regs;
  end
endmodule

// File: rtl/fd_pc_ctl.sv
`timescale 1ns/1ps
module fd_pc_ctl
  import fd_pkg::*;
#(
  parameter int AW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer,
  input  logic          is_halt,
  input  logic          is_bad,
  input  logic          redir,
  input  logic [AW-1:0] redir_pc,
  input  logic [AW-1:0] valp,
  output logic [AW-1:0] pc,
  output logic [1:0]    stat,
  output logic          running
);
  logic stop_now;
  assign running  = (stat == ST_RUN);
  assign stop_now = xfer && (is_halt || is_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      stat <= ST_RUN;
    end else if (running) begin
      if (stop_now)   stat <= is_bad ? ST_BAD : ST_HALT;
      else if (redir) pc   <= redir_pc;
      else if (xfer)  pc   <= valp;
    end
  end

  // R10
  frozen_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(pc));
  // R10
  sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != ST_RUN) |=> $stable(stat));
  // R9
  redirect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && redir && !stop_now) |=> (pc == $past(redir_pc)));
  // R8
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && xfer && !redir && !stop_now) |=> (pc == $past(valp)));
endmodule

// File: rtl/fetch_decode.sv
`timescale 1ns/1ps
module fetch_decode
  import fd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  localparam int WIN_W = 8 * (CW / 8 + 2)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_vld,
  output logic             win_rdy,
  input  logic [WIN_W-1:0] win_data,
  input  logic             redir,
  input  logic [AW-1:0]    redir_pc,
  output logic             dec_vld,
  input  logic             dec_rdy,
  output logic [3:0]       icode,
  output logic [3:0]       ifun,
  output logic [3:0]       ra,
  output logic [3:0]       rb,
  output logic [CW-1:0]    valc,
  output logic [2:0]       ilen,
  output logic [AW-1:0]    valp,
  output logic             bad,
  output logic [AW-1:0]    pc,
  output logic [1:0]       stat
);
  fmt_t fmt;
  logic running;
  logic xfer;

  fd_len_dec u_len (
    .op_byte (win_data[7:0]),
    .fmt     (fmt)
  );

  fd_field_ext #(.CW(CW)) u_fld (
    .win  (win_data),
    .fmt  (fmt),
    .ra   (ra),
    .rb   (rb),
    .valc (valc)
  );

  assign icode   = win_data[7:4];
  assign ifun    = win_data[3:0];
  assign ilen    = fmt.len;
  assign bad     = fmt.bad;
  assign valp    = pc + AW'(fmt.len);
  assign dec_vld = win_vld & running;
  assign win_rdy = dec_rdy & running;
  assign xfer    = dec_vld & dec_rdy;

  fd_pc_ctl #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (xfer),
    .is_halt  (icode == IC_HALT),
    .is_bad   (fmt.bad),
    .redir    (redir),
    .redir_pc (redir_pc),
    .valp     (valp),
    .pc       (pc),
    .stat     (stat),
    .running  (running)
  );

  // R3
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> (ilen == 3'd1 || ilen == 3'd2 || ilen == 3'd5 || ilen == 3'd6));
  // R11
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != ST_RUN) |-> (!dec_vld && !win_rdy));
endmodule

// File: tb/fetch_decode_test.sv
`timescale 1ns/1ps
module fetch_decode_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        win_vld = 0, dec_rdy = 0, redir = 0;
  logic [47:0] win_data = '0;
  logic [31:0] redir_pc = '0;
  logic        win_rdy, dec_vld, bad;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, valp, pc;
  logic [2:0]  ilen;
  logic [1:0]  stat;

  always #5 clk = ~clk;

  fetch_decode uut (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_rdy(win_rdy),
    .win_data(win_data), .redir(redir), .redir_pc(redir_pc),
    .dec_vld(dec_vld), .dec_rdy(dec_rdy), .icode(icode), .ifun(ifun),
    .ra(ra), .rb(rb), .valc(valc), .ilen(ilen), .valp(valp), .bad(bad),
    .pc(pc), .stat(stat)
  );

  int checks = 0, errors = 0;
  logic [7:0]  mem [64];
  logic [31:0] m_pc;
  int          m_stat;
  bit          last_redir;
  logic [31:0] lfsr = 32'h1D872B41;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input logic [31:0] a);
    return mem[a[5:0]];
  endfunction

  task automatic put(input int a, input logic [7:0] v);
    mem[a] = v;
  endtask

  function automatic int rnd(input int n);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]) % n;
  endfunction

  // one cycle: drive, compare against the behavioural model, advance the model
  task automatic step(input bit v, input bit r, input bit rd_en, input logic [31:0] rp);
    logic [7:0] b [6];
    int ic, fn, len, e_ra, e_rb;
    logic [31:0] e_valc, e_valp;
    bit e_bad, run, xf;
    @(negedge clk);
    for (int i = 0; i < 6; i++) b[i] = rd(m_pc + i);
    win_data = {b[5], b[4], b[3], b[2], b[1], b[0]};
    win_vld = v; dec_rdy = r; redir = rd_en; redir_pc = rp;
    #2;
    ic = b[0][7:4]; fn = b[0][3:0];
    e_bad = (ic > 11) || (ic == 6 && fn > 3) || (ic == 7 && fn > 6);
    if (ic == 0 || ic == 1 || ic == 9 || ic > 11) len = 1;
    else if (ic == 2 || ic == 6 || ic == 10 || ic == 11) len = 2;
    else if (ic == 7 || ic == 8) len = 5;
    else len = 6;
    e_ra = 8; e_rb = 8;
    if (len == 2 || len == 6) begin e_ra = b[1][7:4]; e_rb = b[1][3:0]; end
    if (len == 6) e_valc = {b[5], b[4], b[3], b[2]};
    else if (len == 5) e_valc = {b[4], b[3], b[2], b[1]};
    else e_valc = 0;
    e_valp = m_pc + len;
    run = (m_stat == 0);
    chk(pc == m_pc, last_redir ? "R9 pc" : "R8 pc", pc, m_pc);
    chk(stat == m_stat[1:0], "R10 stat", stat, m_stat);
    chk(dec_vld == (v && run), "R11 dec_vld", dec_vld, v && run);
    chk(win_rdy == (r && run), "R11 win_rdy", win_rdy, r && run);
    chk(icode == ic[3:0] && ifun == fn[3:0], "R2 fields", {icode, ifun}, {ic[3:0], fn[3:0]});
    chk(ilen == len[2:0], "R3 ilen", ilen, len);
    chk(ra == e_ra[3:0] && rb == e_rb[3:0], "R4 regs", {ra, rb}, {e_ra[3:0], e_rb[3:0]});
    chk(valc == e_valc, "R5 valc", valc, e_valc);
    chk(valp == e_valp, "R6 valp", valp, e_valp);
    chk(bad == e_bad, "R7 bad", bad, e_bad);
    xf = v && r && run;
    last_redir = 0;
    if (run) begin
      if (xf && (ic == 0 || e_bad)) m_stat = e_bad ? 2 : 1;
      else if (rd_en) begin m_pc = rp; last_redir = 1; end
      else if (xf) m_pc = e_valp;
    end
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; win_vld = 0; dec_rdy = 0; redir = 0;
    m_pc = 0; m_stat = 0; last_redir = 0;
    @(negedge clk);
    #1;
    chk(pc == 0 && stat == 0, "R1 reset", {pc, stat}, 0);
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int starts [6] = '{0, 6, 12, 17, 23, 28};
    int n;
    for (int i = 0; i < 64; i++) mem[i] = 8'h10;
    put(0,8'h30); put(1,8'h82); put(2,8'h78); put(3,8'h56); put(4,8'h34); put(5,8'h12);
    put(6,8'h20); put(7,8'h12);
    put(8,8'h60); put(9,8'h12);
    put(10,8'h61); put(11,8'h34);
    put(12,8'h73); put(13,8'h14); put(14,8'h00); put(15,8'h00); put(16,8'h00);
    put(17,8'h80); put(18,8'h20); put(19,8'h00); put(20,8'h00); put(21,8'h00);
    put(22,8'h90);
    put(23,8'hA0); put(24,8'h28);
    put(25,8'hB0); put(26,8'h38);
    put(27,8'h10);
    put(28,8'h40); put(29,8'h12); put(30,8'h01); put(31,8'h02); put(32,8'h03); put(33,8'h04);
    put(34,8'h50); put(35,8'h34); put(36,8'hAA); put(37,8'hBB); put(38,8'hCC); put(39,8'hDD);
    put(40,8'h00);
    put(44,8'hC0);
    put(46,8'h64); put(47,8'h12);
    put(48,8'h77); put(49,8'h11);
    put(53,8'h76); put(54,8'hEF); put(55,8'hBE); put(56,8'hAD); put(57,8'hDE);
    put(58,8'h63); put(59,8'h45);
    put(60,8'h00);
    put(62,8'h30); put(63,8'h81);

    // main program under irregular handshakes and redirects (R2..R9, R11)
    do_reset();
    n = 0;
    while (m_stat == 0 && n < 400) begin
      step(rnd(4) != 0, rnd(3) != 0, (n < 60) && (rnd(12) == 0), starts[rnd(6)]);
      n++;
    end
    // halted: redirect and offers ignored (R10)
    for (int i = 0; i < 5; i++) step(1, 1, 1, 32'h0000_0006);

    // wrap-around of the fall-through address (R6), then illegal code C (R7, R10)
    do_reset();
    step(0, 0, 1, 32'hFFFF_FFFE);
    step(1, 1, 0, 0);
    step(0, 1, 1, 44);
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0);

    // arithmetic function out of range (R7, R10)
    do_reset();
    step(1, 0, 1, 46);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0);

    // jump function out of range (R7, R10)
    do_reset();
    step(0, 0, 1, 48);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0);

    // legal limits: jump fn 6, arithmetic fn 3, halt (R5, R7, R10)
    do_reset();
    step(0, 0, 1, 53);
    for (int i = 0; i < 8; i++) step(1, i != 1, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule